// File: doc/BRIEF.md
# Programmable Round and Saturate Stage

This block post-processes a 44-bit two's-complement accumulator word. Each input word is accepted on a valid strobe. It is first rounded, if rounding is enabled, to a bit position taken from a 16-entry window near the bottom of the word. It is then clamped, if saturation is enabled, to a signed field whose sign bit is taken from a 16-entry window near the top of the word. The result leaves through a single register stage, together with a valid strobe and a flag that marks words that were clamped.

The block has two clamping modes. The asymmetric mode uses the full two's-complement range of the selected field. The symmetric mode never emits the most negative code of that field. Instead, the negative limit is raised by one unit of the output's least significant weight, and that weight is set by the active rounding position. Configuration inputs are expected to stay fixed while data flows.

Top module: `rndsat_unit`

## Requirements
- R1: `res_valid` equals `src_valid` delayed by exactly one clock, and every accepted word yields exactly one result in order.
- R2: While `rst` is high, and on the first edge after it falls, `res_valid`, `res_clip` and `res_word` are all zero.
- R3: With `round_on`=1 the rounding position is p = 6 + `round_sel` (bits 6..21). The unit adds 2^(p-1) to the input and then clears bits p-1..0, which is round-half-up for both signs. With `round_on`=0 the word passes unrounded.
- R4: With `clip_on`=1 the sign bit of the saturated field is m = 28 + `clip_sel` (bits 28..43). A value within range passes unchanged with `res_clip`=0.
- R5: A value greater than 2^m-1 yields 2^m-1, zero-extended above bit m, with `res_clip`=1.
- R6: In asymmetric mode (`clip_sym`=0), a value below -2^m yields -2^m, sign-extended to 44 bits, with `res_clip`=1.
- R7: In symmetric mode (`clip_sym`=1) the negative limit is -2^m + 2^q. Here q = p when rounding is on, and q = 0 when it is off. Any value below that limit, including exactly -2^m with rounding off, yields the limit with `res_clip`=1.
- R8: Rounding happens before saturation in extended precision. A carry from rounding that crosses the positive limit, or that crosses bit 43, is clamped and flagged.
- R9: With `clip_on`=0 no clamping happens and `res_clip` stays 0. The output is the low 44 bits of the (possibly rounded) value.
- R10: `res_clip` is high only together with `res_valid`. `res_word` holds its value over cycles without a valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Input word strobe |
| src_word | input | 44 | Signed input word |
| round_on | input | 1 | Enable rounding |
| round_sel | input | 4 | Rounding position select, p = 6 + value |
| clip_on | input | 1 | Enable saturation |
| clip_sel | input | 4 | Saturation sign-bit select, m = 28 + value |
| clip_sym | input | 1 | 1 = symmetric limits, 0 = asymmetric |
| res_valid | output | 1 | Result strobe |
| res_word | output | 44 | Processed signed word |
| res_clip | output | 1 | Result was clamped |

## Verification
The bench compares every result against a wide-integer model of the requirements. It targets the exact most negative code in symmetric mode, which a design that only tests the upper bits would pass through unflagged. It checks the symmetric minimum with rounding on, where a design that adds the +1 at bit 0 would leave a nonzero fraction below the rounding position. It also feeds values whose rounding carry crosses the positive limit or bit 43 itself. A design that saturates before rounding, or that rounds in 44 bits only, would emit a wrapped or over-range word there. Negative half-way inputs check that ties round upward for both signs.

// File: rtl/rndsat_pkg.sv
package rndsat_pkg;
  localparam int DEF_DATA_W   = 44;
  localparam int DEF_SEL_W    = 4;
  localparam int DEF_RND_BASE = 6;
  localparam int DEF_SAT_BASE = 28;

  typedef struct packed {
    logic round_on;
    logic clip_on;
    logic clip_sym;
  } mode_t;
endpackage

// File: rtl/rndsat_round.sv
module rndsat_round #(
  parameter int DATA_W   = 44,
  parameter int SEL_W    = 4,
  parameter int RND_BASE = 6,
  localparam int EXT_W   = DATA_W + 1,
  localparam int SH_W    = $clog2(EXT_W + 1)
) (
  input  logic [DATA_W-1:0] din,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic [EXT_W-1:0]  dout,
  output logic [SH_W-1:0]   lsb_pos
);
  logic [SH_W-1:0]  pos;
  logic [EXT_W-1:0] ext, half, keep_mask;

  always_comb begin
    pos       = SH_W'(RND_BASE) + SH_W'(sel);
    ext       = {din[DATA_W-1], din};
    half      = EXT_W'(1) << (pos - SH_W'(1));
    keep_mask = ~((EXT_W'(1) << pos) - EXT_W'(1));
    if (en) begin
      dout    = (ext + half) & keep_mask;
      lsb_pos = pos;
    end else begin
      dout    = ext;
      lsb_pos = '0;
    end
  end
endmodule

// File: rtl/rndsat_limits.sv
module rndsat_limits #(
  parameter int DATA_W   = 44,
  parameter int SEL_W    = 4,
  parameter int SAT_BASE = 28,
  localparam int EXT_W   = DATA_W + 1,
  localparam int SH_W    = $clog2(EXT_W + 1)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             sym,
  input  logic [SH_W-1:0]  lsb_pos,
  output logic [EXT_W-1:0] hi_lim,
  output logic [EXT_W-1:0] lo_lim
);
  logic [SH_W-1:0]  msb;
  logic [EXT_W-1:0] top_w;

  always_comb begin
    msb    = SH_W'(SAT_BASE) + SH_W'(sel);
    top_w  = EXT_W'(1) << msb;
    hi_lim = top_w - EXT_W'(1);
    lo_lim = (~top_w) + EXT_W'(1);
    if (sym) lo_lim = lo_lim + (EXT_W'(1) << lsb_pos);
  end
endmodule

// File: rtl/rndsat_clamp.sv
module rndsat_clamp #(
  parameter int DATA_W = 44,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [EXT_W-1:0]  val,
  input  logic [EXT_W-1:0]  hi_lim,
  input  logic [EXT_W-1:0]  lo_lim,
  input  logic              en,
  output logic [DATA_W-1:0] dout,
  output logic              clip
);
  logic over, under;

  always_comb begin
    over  = $signed(val) > $signed(hi_lim);
    under = $signed(val) < $signed(lo_lim);
    clip  = en && (over || under);
    if (en && over)       dout = hi_lim[DATA_W-1:0];
    else if (en && under) dout = lo_lim[DATA_W-1:0];
    else                  dout = val[DATA_W-1:0];
  end
endmodule

// File: rtl/rndsat_unit.sv
module rndsat_unit
  import rndsat_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int SEL_W    = DEF_SEL_W,
  parameter int RND_BASE = DEF_RND_BASE,
  parameter int SAT_BASE = DEF_SAT_BASE,
  localparam int EXT_W   = DATA_W + 1,
  localparam int SH_W    = $clog2(EXT_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_word,
  input  logic              round_on,
  input  logic [SEL_W-1:0]  round_sel,
  input  logic              clip_on,
  input  logic [SEL_W-1:0]  clip_sel,
  input  logic              clip_sym,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_word,
  output logic              res_clip
);
  mode_t            mode;
  logic [EXT_W-1:0] rounded, hi_lim, lo_lim;
  logic [SH_W-1:0]  lsb_pos;
  logic [DATA_W-1:0] clamped;
  logic              clip_now;

  assign mode = '{round_on: round_on, clip_on: clip_on, clip_sym: clip_sym};

  rndsat_round #(.DATA_W(DATA_W), .SEL_W(SEL_W), .RND_BASE(RND_BASE)) u_round (
    .din(src_word), .en(mode.round_on), .sel(round_sel),
    .dout(rounded), .lsb_pos(lsb_pos)
  );

  rndsat_limits #(.DATA_W(DATA_W), .SEL_W(SEL_W), .SAT_BASE(SAT_BASE)) u_limits (
    .sel(clip_sel), .sym(mode.clip_sym), .lsb_pos(lsb_pos),
    .hi_lim(hi_lim), .lo_lim(lo_lim)
  );

  rndsat_clamp #(.DATA_W(DATA_W)) u_clamp (
    .val(rounded), .hi_lim(hi_lim), .lo_lim(lo_lim), .en(mode.clip_on),
    .dout(clamped), .clip(clip_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_clip  <= 1'b0;
      res_word  <= '0;
    end else begin
      res_valid <= src_valid;
      res_clip  <= src_valid && clip_now;
      if (src_valid) res_word <= clamped;
    end
  end

  // R1: one-cycle valid latency
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    src_valid |=> res_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !src_valid |=> !res_valid);
  // R10: flag only with a result, word held otherwise
  a_r10_clip_with_valid: assert property (@(posedge clk) disable iff (rst)
    res_clip |-> res_valid);
  a_r10_word_held: assert property (@(posedge clk) disable iff (rst)
    !src_valid |=> $stable(res_word));
  // R9: no flag when saturation is off
  a_r9_no_clip_when_off: assert property (@(posedge clk) disable iff (rst)
    (src_valid && !clip_on) |=> !res_clip);
  // R5/R6/R7: a clamped word fits the selected field (bits above m equal bit m)
  a_r5_clip_fits_field: assert property (@(posedge clk) disable iff (rst)
    (src_valid && clip_on) |=>
      (($signed(res_word) >>> (SAT_BASE + int'($past(clip_sel)))) == 0 ||
       ($signed(res_word) >>> (SAT_BASE + int'($past(clip_sel)))) == -1));
  // R3: unclamped rounded word has no bits below the rounding position
  a_r3_low_bits_clear: assert property (@(posedge clk) disable iff (rst)
    (src_valid && round_on) |=> (res_clip ||
      ((res_word & ((DATA_W'(1) << (RND_BASE + int'($past(round_sel)))) - DATA_W'(1))) == '0)));
endmodule

// File: tb/rndsat_unit_test.sv
module rndsat_unit_test;
  localparam int CLK_NS = 10;
  localparam int W = 44;

  logic clk = 1'b0, rst = 1'b1;
  logic src_valid = 1'b0;
  logic [W-1:0] src_word = '0;
  logic round_on = 1'b0, clip_on = 1'b0, clip_sym = 1'b0;
  logic [3:0] round_sel = '0, clip_sel = '0;
  logic res_valid, res_clip;
  logic [W-1:0] res_word;

  typedef struct {
    logic [W-1:0] word;
    logic         clip;
    string        tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0, pushed = 0, popped = 0;
  bit finished = 0;

  rndsat_unit uut (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_word(src_word),
    .round_on(round_on), .round_sel(round_sel), .clip_on(clip_on),
    .clip_sel(clip_sel), .clip_sym(clip_sym), .res_valid(res_valid),
    .res_word(res_word), .res_clip(res_clip)
  );

  always #(CLK_NS/2) clk = ~clk;

  // Reference computed from the requirement text in 64-bit integers
  function automatic exp_t model(input logic [W-1:0] x, input string tag);
    longint v, p, m, hi, lo;
    exp_t e;
    v = longint'($signed(x));
    p = 6 + longint'(round_sel);
    m = 28 + longint'(clip_sel);
    if (round_on) v = ((v + (64'sd1 <<< (p - 1))) >>> p) <<< p;
    e.clip = 1'b0;
    if (clip_on) begin
      hi = (64'sd1 <<< m) - 1;
      lo = -(64'sd1 <<< m);
      if (clip_sym) lo = lo + (round_on ? (64'sd1 <<< p) : 64'sd1);
      if (v > hi) begin v = hi; e.clip = 1'b1; end
      else if (v < lo) begin v = lo; e.clip = 1'b1; end
    end
    e.word = v[W-1:0];
    e.tag = tag;
    return e;
  endfunction

  task automatic fail(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    errors++;
    $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  task automatic setup(input logic ro, input logic [3:0] rs, input logic co,
                       input logic [3:0] cs, input logic sy);
    @(negedge clk);
    src_valid = 1'b0;
    round_on = ro; round_sel = rs; clip_on = co; clip_sel = cs; clip_sym = sy;
  endtask

  // Send with a hand-computed expectation, also cross-checked against the model
  task automatic send_lit(input logic [W-1:0] x, input logic [W-1:0] ew,
                          input logic ec, input string tag);
    exp_t e, m;
    e.word = ew; e.clip = ec; e.tag = tag;
    m = model(x, tag);
    checks++;
    if (m.word !== ew || m.clip !== ec) fail({tag, " model"}, m.word, ew);
    @(negedge clk);
    src_valid = 1'b1; src_word = x;
    sb.push_back(e); pushed++;
  endtask

  task automatic send(input logic [W-1:0] x, input string tag);
    @(negedge clk);
    src_valid = 1'b1; src_word = x;
    sb.push_back(model(x, tag)); pushed++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (res_valid) begin
        checks++;
        if (sb.size() == 0) begin
          fail("R1 unexpected result", res_word, '0);
        end else begin
          exp_t e;
          e = sb.pop_front(); popped++;
          if (res_word !== e.word) fail(e.tag, res_word, e.word);
          else if (res_clip !== e.clip)
            fail({e.tag, " clip flag"}, W'(res_clip), W'(e.clip));
        end
      end else if (res_clip) begin
        checks++;
        fail("R10 clip without valid", W'(res_clip), '0);
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_clip !== 1'b0 || res_word !== '0)
      fail("R2 reset state", res_word, '0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_word !== '0) fail("R2 after reset", res_word, '0);

    // R3 rounding at p=6, ties upward for both signs
    setup(1, 4'd0, 0, 4'd0, 0);
    send_lit(44'h000_0000_0020, 44'h000_0000_0040, 0, "R3 tie positive");
    send_lit(44'h000_0000_001F, 44'h000_0000_0000, 0, "R3 below half");
    send_lit(44'hFFF_FFFF_FFE0, 44'h000_0000_0000, 0, "R3 tie negative");
    send_lit(44'hFFF_FFFF_FFDF, 44'hFFF_FFFF_FFC0, 0, "R3 negative past half");
    // R9 saturation off, rounding on/off
    send_lit(44'h592_6AC0_1342, 44'h592_6AC0_1340, 0, "R9 round only");
    setup(0, 4'd0, 0, 4'd0, 0);
    send_lit(44'h592_6AC0_1342, 44'h592_6AC0_1342, 0, "R9 passthrough");
    // R4/R5/R6 at 32-bit field (m=31), asymmetric
    setup(0, 4'd0, 1, 4'd3, 0);
    send_lit(44'h000_7FFF_FFFF, 44'h000_7FFF_FFFF, 0, "R4 max in range");
    send_lit(44'h001_0000_0000, 44'h000_7FFF_FFFF, 1, "R5 positive clamp");
    send_lit(44'hFFF_0000_0000, 44'hFFF_8000_0000, 1, "R6 negative clamp");
    send_lit(44'hFFF_8000_0000, 44'hFFF_8000_0000, 0, "R6 min in range");
    // 36-bit field (m=35)
    setup(0, 4'd0, 1, 4'd7, 0);
    send_lit(44'h592_6AC0_1342, 44'h007_FFFF_FFFF, 1, "R5 36-bit positive");
    send_lit(44'hADA_38D2_2100, 44'hFF8_0000_0000, 1, "R6 36-bit negative");
    setup(0, 4'd0, 1, 4'd7, 1);
    send_lit(44'hADA_38D2_2100, 44'hFF8_0000_0001, 1, "R7 36-bit symmetric");
    // R7 symmetric, exact min code, rounding off and on
    setup(0, 4'd0, 1, 4'd3, 1);
    send_lit(44'hFFF_8000_0000, 44'hFFF_8000_0001, 1, "R7 exact min code");
    send_lit(44'hFFF_8000_0001, 44'hFFF_8000_0001, 0, "R7 sym min in range");
    setup(1, 4'd2, 1, 4'd3, 1);
    send_lit(44'hFFF_0000_0000, 44'hFFF_8000_0100, 1, "R7 min at round lsb");
    send_lit(44'hFFF_8000_0000, 44'hFFF_8000_0100, 1, "R7 exact min rounded");
    // R8 rounding carry crosses limit / bit 43
    setup(1, 4'd0, 1, 4'd3, 0);
    send_lit(44'h000_7FFF_FFE0, 44'h000_7FFF_FFFF, 1, "R8 carry over limit");
    setup(1, 4'd0, 1, 4'd15, 0);
    send_lit(44'h7FF_FFFF_FFFF, 44'h7FF_FFFF_FFFF, 1, "R8 carry over bit43");
    setup(0, 4'd0, 1, 4'd3, 0);
    send_lit(44'h000_7FFF_FFE0, 44'h000_7FFF_FFE0, 0, "R8 no round no clamp");

    // R10 word held across idle cycles
    idle(2);
    held = res_word;
    idle(3);
    checks++;
    if (res_word !== held) fail("R10 word held", res_word, held);

    // Sweep of configurations with pseudo-random words, back to back
    for (int c = 0; c < 24; c++) begin
      setup(1'(c % 2), 4'($urandom_range(0, 15)), 1'((c / 2) % 2 == 0 ? 1 : (c % 3 != 0)),
            4'($urandom_range(0, 15)), 1'((c / 4) % 2));
      for (int k = 0; k < 20; k++) begin
        logic [W-1:0] x;
        x = {$urandom, $urandom};
        if (k % 4 == 1) x = {{12{x[43]}}, x[31:0]};
        send(x, "R4 R5 R6 R7 sweep");
      end
    end

    idle(4);
    checks++;
    if (pushed != popped || sb.size() != 0)
      fail("R1 result count", W'(popped), W'(pushed));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule